// File: doc/BRIEF.md
# Zero-Flagged Cache Data Array

This block is the data store of one cache way. Each word is split into equal groups of bits. Every group has one stored flag that marks the group as all zero. A store checks the incoming data group by group in the same cycle as the write. If a group is all zero, the block sets the flag and does not enable that group's sub-array, so those cells are left alone. If a group holds any one bit, the block clears the flag and writes the group.

On a load, the block reads the flags at the same time as it decodes the index. It enables only the sub-arrays of groups whose flag is clear. The flagged groups come out as zero without any access to their storage. The result appears one cycle after the request, which leaves the surrounding pipeline free to do its tag compare in parallel.

The flags never leave the block. Two saturating counters report how many group accesses reached a sub-array and how many were suppressed. Together they give a simple proxy for array energy.

Top module: `dzc_cache_array`

## Requirements
- R1: With the default grouping of 8 bits, a 32-bit word has 4 groups, and group g covers bits [8g+7:8g]. The group width is a parameter (4, 8, 16 or 32) and must divide the word width.
- R2: On a write, a selected group whose data is all zero sets its flag and is not written. A selected group with any one bit clears its flag and is written.
- R3: On a read, every group whose stored flag is set returns zero on rdata, and its sub-array is not enabled.
- R4: rvalid is high in exactly the cycle after a read request (req=1, we=0), with rdata valid in that cycle. It is low after any cycle that carries no read.
- R5: A read of an index in the cycle right after a write to that index returns the newly written word, including the groups that were zeroed.
- R6: On a write, grp_mask bit g selects group g. Groups whose mask bit is 0 keep both their data and their flag.
- R7: Synchronous active-high reset makes every word zero with every flag set, and it clears both counters and rvalid. A read after reset returns 0 with all groups suppressed.
- R8: cnt_enabled rises by the number of groups whose sub-array is enabled in a request cycle. cnt_suppressed rises by the number of groups that are suppressed. A write counts only its selected groups, and idle cycles change neither counter.
- R9: Each counter saturates at 2^CNT_W-1 and stays there.
- R10: A group that held non-zero data and is then written with zero reads back as zero, even though its old cells were not overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read (when req=1) |
| grp_mask | input | W/GRP | Per-group write select |
| addr | input | IDX_W | Word index |
| wdata | input | W | Store data |
| rdata | output | W | Load data, valid with rvalid |
| rvalid | output | 1 | Load data valid, one cycle after a read request |
| cnt_enabled | output | CNT_W | Saturating count of enabled group accesses |
| cnt_suppressed | output | CNT_W | Saturating count of suppressed group accesses |

## Verification
On every cycle, the assertions check the following. A write enable never reaches a group whose store data is zero. A read of a flagged group always leaves a zero group register. rvalid follows read requests with one cycle of latency. The counters never fall, and they hold once saturated. Only the bench scenarios can show the end-to-end data behaviour: partial masks that keep other groups intact, stale cells hidden behind a set flag, read-after-write in the next cycle, and exact counter totals up to and through saturation.

// File: rtl/dzc_pkg.sv
package dzc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } acc_t;

    function automatic op_e op_decode(input logic req, input logic we);
        if (!req)   return OP_IDLE;
        else if (we) return OP_WRITE;
        else         return OP_READ;
    endfunction

    function automatic acc_t acc_of(input op_e op);
        acc_t a;
        a.rd = (op == OP_READ);
        a.wr = (op == OP_WRITE);
        return a;
    endfunction

endpackage

// File: rtl/dzc_zero_detect.sv
module dzc_zero_detect #(
    parameter int W   = 32,
    parameter int GRP = 8,
    localparam int G  = W / GRP
) (
    input  logic [W-1:0] wdata,
    output logic [G-1:0] zf
);
    // One flag per group: high when every bit of the group is zero (R1, R2)
    for (genvar g = 0; g < G; g++) begin : g_det
        assign zf[g] = ~|wdata[g*GRP +: GRP];
    end
endmodule

// File: rtl/dzc_store.sv
module dzc_store
    import dzc_pkg::*;
#(
    parameter int W     = 32,
    parameter int GRP   = 8,
    parameter int DEPTH = 16,
    localparam int G     = W / GRP,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [IDX_W-1:0] addr,
    input  logic [G-1:0]     mask,
    input  logic [W-1:0]     wdata,
    input  logic [G-1:0]     zf,
    output logic [W-1:0]     rdata,
    output logic             rvalid,
    output logic [G-1:0]     grp_on,
    output logic [G-1:0]     grp_off
);
    acc_t acc;
    assign acc = acc_of(op);

    // Flag array, read in the decode cycle
    logic [G-1:0] flag_mem [DEPTH];
    logic [G-1:0] flags_rd;
    assign flags_rd = flag_mem[addr];

    logic [G-1:0] wr_en, wr_sup, rd_en, rd_sup;
    assign wr_en  = {G{acc.wr}} & mask & ~zf;
    assign wr_sup = {G{acc.wr}} & mask &  zf;
    assign rd_en  = {G{acc.rd}} & ~flags_rd;
    assign rd_sup = {G{acc.rd}} &  flags_rd;
    assign grp_on  = wr_en | rd_en;
    assign grp_off = wr_sup | rd_sup;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) flag_mem[i] <= '1;
        end else if (acc.wr) begin
            for (int g = 0; g < G; g++)
                if (mask[g]) flag_mem[addr][g] <= zf[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid <= 1'b0;
        else     rvalid <= acc.rd;
    end

    // One gated sub-array per group
    for (genvar g = 0; g < G; g++) begin : g_bank
        logic [GRP-1:0] bank [DEPTH];
        logic [GRP-1:0] rgrp_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            end else if (wr_en[g]) begin
                bank[addr] <= wdata[g*GRP +: GRP];
            end
        end

        always_ff @(posedge clk) begin
            if (rst)            rgrp_q <= '0;
            else if (rd_en[g])  rgrp_q <= bank[addr];
            else if (rd_sup[g]) rgrp_q <= '0;
        end

        assign rdata[g*GRP +: GRP] = rgrp_q;

        // R2: a group of zero store data never sees its write enable
        p_wr_gate_r2: assert property (@(posedge clk) disable iff (rst)
            wr_en[g] |-> (wdata[g*GRP +: GRP] != '0));

        // R3: a flagged group read leaves zero in the output group
        p_rd_zero_r3: assert property (@(posedge clk) disable iff (rst)
            (acc.rd && flags_rd[g]) |=> (rgrp_q == '0));
    end

    // R4: read latency of one cycle
    p_rvalid_lat_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ) |=> rvalid);
    p_rvalid_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (op != OP_READ) |=> !rvalid);
endmodule

// File: rtl/dzc_activity.sv
module dzc_activity #(
    parameter int G     = 4,
    parameter int CNT_W = 16,
    localparam int IW   = $clog2(G + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [G-1:0]     hits,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

    logic [IW-1:0]  inc;
    logic [CNT_W:0] sum;
    assign inc = IW'($countones(hits));
    assign sum = {1'b0, cnt} + (CNT_W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (sum > MAXV)  cnt <= '1;
        else                  cnt <= sum[CNT_W-1:0];
    end

    // R8: counter never decreases
    p_monotone_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt >= $past(cnt)));
    // R9: a saturated counter stays saturated
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1) |=> (cnt == '1));
endmodule

// File: rtl/dzc_cache_array.sv
module dzc_cache_array
    import dzc_pkg::*;
#(
    parameter int W     = 32,
    parameter int GRP   = 8,
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int G     = W / GRP,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             we,
    input  logic [G-1:0]     grp_mask,
    input  logic [IDX_W-1:0] addr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic             rvalid,
    output logic [CNT_W-1:0] cnt_enabled,
    output logic [CNT_W-1:0] cnt_suppressed
);
    op_e          op;
    logic [G-1:0] zf, grp_on, grp_off;

    assign op = op_decode(req, we);

    dzc_zero_detect #(.W(W), .GRP(GRP)) u_det (
        .wdata (wdata),
        .zf    (zf)
    );

    dzc_store #(.W(W), .GRP(GRP), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .addr    (addr),
        .mask    (grp_mask),
        .wdata   (wdata),
        .zf      (zf),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .grp_on  (grp_on),
        .grp_off (grp_off)
    );

    dzc_activity #(.G(G), .CNT_W(CNT_W)) u_cnt_on (
        .clk  (clk),
        .rst  (rst),
        .hits (grp_on),
        .cnt  (cnt_enabled)
    );

    dzc_activity #(.G(G), .CNT_W(CNT_W)) u_cnt_off (
        .clk  (clk),
        .rst  (rst),
        .hits (grp_off),
        .cnt  (cnt_suppressed)
    );

    // R8: an idle cycle leaves both counters unchanged
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!req && cnt_enabled != '1 && cnt_suppressed != '1)
        |=> ($stable(cnt_enabled) && $stable(cnt_suppressed)));
endmodule

// File: tb/test_dzc_cache_array.sv
module test_dzc_cache_array;
    localparam int W = 32, GRP = 8, DEPTH = 16, CNT_W = 8;
    localparam int G = W / GRP;
    localparam int MAXC = (1 << CNT_W) - 1;

    logic clk = 0, rst = 1, req = 0, we = 0;
    logic [G-1:0] grp_mask = '0;
    logic [3:0] addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic rvalid;
    logic [CNT_W-1:0] cnt_enabled, cnt_suppressed;

    always #4 clk = ~clk; // 125 MHz

    dzc_cache_array #(.W(W), .GRP(GRP), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_dzc_cache_array (
        .clk(clk), .rst(rst), .req(req), .we(we), .grp_mask(grp_mask), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .cnt_enabled(cnt_enabled), .cnt_suppressed(cnt_suppressed)
    );

    int n_checks = 0, n_fail = 0;
    logic [W-1:0] model [DEPTH];
    int m_on = 0, m_off = 0;
    logic [W-1:0] exp_q [$];
    string tag_q [$];
    bit done = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    task automatic do_write(input int a, input logic [W-1:0] d, input logic [G-1:0] m);
        @(negedge clk);
        req = 1; we = 1; addr = 4'(a); wdata = d; grp_mask = m;
        for (int g = 0; g < G; g++) if (m[g]) begin
            if (d[g*GRP +: GRP] == '0) m_off++; else m_on++;
            model[a][g*GRP +: GRP] = d[g*GRP +: GRP];
        end
    endtask

    task automatic do_read(input int a, input string tag);
        @(negedge clk);
        req = 1; we = 0; addr = 4'(a); grp_mask = '0; wdata = '0;
        exp_q.push_back(model[a]);
        tag_q.push_back(tag);
        for (int g = 0; g < G; g++)
            if (model[a][g*GRP +: GRP] == '0) m_off++; else m_on++;
    endtask

    task automatic idle();
        @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic check_cnt(input string tag);
        idle();
        check({tag, " enabled"}, cnt_enabled, sat(m_on));
        check({tag, " suppressed"}, cnt_suppressed, sat(m_off));
    endtask

    // Monitor: pops expected read data in the cycle rvalid is seen
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R4: actual rvalid 1 expected 0 (no read pending)");
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R7: reset state at the ports
        check("R7 rdata", rdata, 0);
        check("R7 rvalid", rvalid, 0);
        check("R7 cnt_enabled", cnt_enabled, 0);
        check("R7 cnt_suppressed", cnt_suppressed, 0);
        do_read(0, "R7 read0");
        do_read(5, "R7 read5");
        do_read(15, "R7 read15");
        check_cnt("R7 all suppressed");

        // R1/R2/R5: mixed zero/non-zero bytes, read in next cycle
        do_write(1, 32'h1200_3400, 4'hF);
        do_read(1, "R5 read-after-write");
        check_cnt("R2 R8 mixed groups");

        // R4: back-to-back reads, then rvalid drops
        do_write(4, 32'hA1B2_C3D4, 4'hF);
        do_read(4, "R4 b2b a");
        do_read(1, "R4 b2b b");
        idle();
        idle();
        check("R4 rvalid low after idle", rvalid, 0);

        // R10: stale non-zero cells hidden by a set flag
        do_write(2, 32'hDEAD_BEEF, 4'hF);
        do_write(2, 32'h00AD_0000, 4'hF);
        do_read(2, "R10 stale masked");
        do_write(2, 32'h0000_0000, 4'hF);
        do_read(2, "R10 all zero");
        check_cnt("R8 after zero writes");

        // R6: partial mask keeps unselected groups
        do_write(3, 32'h1122_3344, 4'hF);
        do_write(3, 32'hFFFF_0055, 4'b0011);
        do_read(3, "R6 partial mask");
        do_write(3, 32'h0000_0000, 4'b1000);
        do_read(3, "R6 zeroed top only");
        do_write(3, 32'h7700_0000, 4'b0000);
        do_read(3, "R6 empty mask no change");
        check_cnt("R8 masked counting");

        // R8: idle cycles do not count
        idle(); idle(); idle();
        check_cnt("R8 idle");

        // R9: saturation
        for (int k = 0; k < 80; k++) do_read(4, "R9 reads");
        check_cnt("R9 saturate");
        for (int k = 0; k < 10; k++) do_read(1, "R9 more");
        check_cnt("R9 hold");
        check("R9 enabled at max", cnt_enabled, MAXC);
        idle(); idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule